// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block decides when a processor core may be handed a hardware call to a fixed service vector. Five request sources feed it, in this index order: external request 0, timer 0, external request 1, timer 1 and the serial port. An enable register gates the sources. It has one bit per source and a master bit above them. A priority register places each source on a low or a high level. The controller remembers which levels are currently being serviced. A return strobe from the core retires the most recent level.

Requests are captured on a sample strobe that the core raises late in each machine cycle. The captured set is judged on a poll strobe during the following machine cycle. At the poll, the call is withheld if any of these holds:
- a routine of equal or higher level is running;
- the core is not in the final cycle of its instruction;
- the instruction is a return-from-interrupt or a write to either configuration register.

A granted call appears as a one-cycle pulse together with the vector and the source index. For a timer source, the same pulse also tells that timer to drop its overflow flag.

Top module: `intc_two_level`

## Requirements
- R1: Synchronous active-low reset clears the enable register (all sources and master bit off), the priority register (all low), both in-service bits, `call_go` and `flag_clr`.
- R2: `req_raw` is captured only on a cycle with `sample_stb` high. A poll judges the captured set, so a flag dropped after capture still wins, and a flag raised after capture is not seen.
- R3: Source i can be granted only when enable bit i and the master bit `en_wd[5]` are both set.
- R4: Any pending high-level source beats every low-level source. Within one level, the lowest index wins (0 first, 4 last).
- R5: A grant is withheld when `in_srv[1]` is set, or when `in_srv[0]` is set and the candidate is low level. A high-level request preempts a running low-level routine.
- R6: A grant is withheld when `last_cyc` is low at the poll.
- R7: A grant is withheld when `instr_reti` or `instr_cfg_wr` is high at the poll.
- R8: `call_vec` = 0x0003 + 8 × index, so 0x0003, 0x000B, 0x0013, 0x001B, 0x0023, and `call_src` = index.
- R9: With a grant of source 1 or 3 (the timers), `flag_clr` is one-hot at that index for the same cycle. Grants of sources 0, 2 and 4 leave `flag_clr` at zero.
- R10: `reti_stb` clears `in_srv[1]` if it is set, otherwise `in_srv[0]`. A low level that was preempted becomes visible again.
- R11: A grant on the edge where `poll_stb` is high gives `call_go` high for exactly the next cycle. `in_srv[1]` (high) or `in_srv[0]` (low) is set from that cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_stb | input | 1 | Late-phase capture strobe of each machine cycle |
| poll_stb | input | 1 | Decision strobe in the following machine cycle |
| last_cyc | input | 1 | Core is in the final cycle of its instruction |
| instr_reti | input | 1 | Current instruction is a return-from-interrupt |
| instr_cfg_wr | input | 1 | Current instruction writes the enable or priority register |
| reti_stb | input | 1 | Retire the highest in-service level |
| req_raw | input | 5 | Live request flags, bit = source index |
| en_we | input | 1 | Enable register write strobe |
| en_wd | input | 6 | Enable data: bits 4..0 per source, bit 5 master |
| pri_we | input | 1 | Priority register write strobe |
| pri_wd | input | 5 | Priority data: 1 = high level |
| call_go | output | 1 | One-cycle call pulse |
| call_vec | output | 16 | Service vector address |
| call_src | output | 3 | Granted source index |
| flag_clr | output | 5 | One-hot flag clear to the granted timer |
| in_srv | output | 2 | In-service bits: [1] high, [0] low |

## Verification
The assertions assume the following about the core's strobes:
- `sample_stb` and `poll_stb` are single-cycle and never high together.
- `reti_stb` is not raised on the same edge as a poll that could grant.
- The core inputs are driven to zero while reset is held.

The stimulus keeps within these assumptions by design. Each machine cycle is a capture cycle followed by a separate poll cycle. Returns are issued only in their own cycle. All inputs change at the falling edge, so every decision edge sees settled values.

// File: rtl/intc_pkg.sv
// Shared types for the two-level interrupt controller.
// Assumes at most eight sources, so a source index fits in three bits.
package intc_pkg;
    localparam int IDX_W = 3;

    // Winner of the arbitration among pending sources.
    typedef struct packed {
        logic             vld;
        logic             hi;
        logic [IDX_W-1:0] idx;
    } cand_t;
endpackage

// File: rtl/intc_sampler.sv
// Captures the live request flags on the sample strobe.
// Assumes the strobe marks the late phase of a machine cycle; the held
// copy is what the next poll judges.
module intc_sampler #(
    parameter int N_SRC = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_stb,
    input  logic [N_SRC-1:0] req_raw,
    output logic [N_SRC-1:0] smp
);
    for (genvar g = 0; g < N_SRC; g++) begin : g_bit
        // Hold one flag between capture strobes.
        always_ff @(posedge clk) begin
            if (!rst_n)          smp[g] <= 1'b0;
            else if (sample_stb) smp[g] <= req_raw[g];
        end
    end
endmodule

// File: rtl/intc_arbiter.sv
// Picks one source from the captured flags. The high level beats the low
// level; within a level the lowest index wins.
// Assumes the master enable is the top bit of the enable vector.
module intc_arbiter #(
    parameter int N_SRC = 5
) (
    input  logic [N_SRC-1:0] smp,
    input  logic [N_SRC:0]   en_q,
    input  logic [N_SRC-1:0] pri_q,
    output intc_pkg::cand_t  cand
);
    localparam int IDX_W = intc_pkg::IDX_W;

    logic [N_SRC-1:0] pend;
    logic [N_SRC-1:0] hi_set;
    logic [N_SRC-1:0] use_set;

    // Pending sources that survive the enables, split by level.
    always_comb begin
        pend    = smp & en_q[N_SRC-1:0] & {N_SRC{en_q[N_SRC]}};
        hi_set  = pend & pri_q;
        use_set = (|hi_set) ? hi_set : pend;
    end

    // Lowest set index in the chosen level.
    always_comb begin
        cand.vld = |use_set;
        cand.hi  = |hi_set;
        cand.idx = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (use_set[i]) cand.idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/intc_srv_track.sv
// Keeps the in-service bit of each priority level. A grant sets the bit of
// its level. A return clears the highest set bit.
// Assumes a return and a grant do not fall on the same edge.
module intc_srv_track (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_stb,
    input  logic       set_hi,
    input  logic       reti_stb,
    output logic [1:0] in_srv
);
    logic [1:0] nxt;

    // Next in-service state from a return and a grant.
    always_comb begin
        nxt = in_srv;
        if (reti_stb) begin
            if (in_srv[1]) nxt[1] = 1'b0;
            else           nxt[0] = 1'b0;
        end
        if (set_stb) begin
            if (set_hi) nxt[1] = 1'b1;
            else        nxt[0] = 1'b1;
        end
    end

    // Level register.
    always_ff @(posedge clk) begin
        if (!rst_n) in_srv <= 2'b00;
        else        in_srv <= nxt;
    end

    a_r10_reti_drops_top: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_stb && in_srv[1] && !(set_stb && set_hi)) |=> !in_srv[1]);
    a_r10_low_exposed: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_stb && in_srv == 2'b11 && !set_stb) |=> in_srv == 2'b01);
    a_r11_high_marked: assert property (@(posedge clk) disable iff (!rst_n)
        (set_stb && set_hi) |=> in_srv[1]);
    a_r11_low_marked: assert property (@(posedge clk) disable iff (!rst_n)
        (set_stb && !set_hi && !reti_stb) |=> in_srv[0]);
endmodule

// File: rtl/intc_two_level.sv
// Two-level priority interrupt controller top. It holds the enable and
// priority registers, applies the three blocking conditions at the poll
// strobe and registers the call outputs.
// Assumes sample and poll strobes are single-cycle and never coincide.
module intc_two_level #(
    parameter int               N_SRC       = 5,
    parameter int               VEC_W       = 16,
    parameter int               VEC_BASE    = 3,
    parameter int               VEC_STEP    = 8,
    parameter logic [N_SRC-1:0] CLR_ON_CALL = 5'b01010
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sample_stb,
    input  logic                       poll_stb,
    input  logic                       last_cyc,
    input  logic                       instr_reti,
    input  logic                       instr_cfg_wr,
    input  logic                       reti_stb,
    input  logic [N_SRC-1:0]           req_raw,
    input  logic                       en_we,
    input  logic [N_SRC:0]             en_wd,
    input  logic                       pri_we,
    input  logic [N_SRC-1:0]           pri_wd,
    output logic                       call_go,
    output logic [VEC_W-1:0]           call_vec,
    output logic [intc_pkg::IDX_W-1:0] call_src,
    output logic [N_SRC-1:0]           flag_clr,
    output logic [1:0]                 in_srv
);
    localparam int IDX_W = intc_pkg::IDX_W;

    logic [N_SRC:0]   en_q;
    logic [N_SRC-1:0] pri_q;
    logic [N_SRC-1:0] smp;
    intc_pkg::cand_t  cand;
    logic             blk_lvl;
    logic             blk_ins;
    logic             grant;

    // Configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            pri_q <= '0;
        end else begin
            if (en_we)  en_q  <= en_wd;
            if (pri_we) pri_q <= pri_wd;
        end
    end

    intc_sampler #(.N_SRC(N_SRC)) u_smp (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_stb (sample_stb),
        .req_raw    (req_raw),
        .smp        (smp)
    );

    intc_arbiter #(.N_SRC(N_SRC)) u_arb (
        .smp   (smp),
        .en_q  (en_q),
        .pri_q (pri_q),
        .cand  (cand)
    );

    // Blocking conditions and the grant decision.
    always_comb begin
        blk_lvl = in_srv[1] | (in_srv[0] & ~cand.hi);
        blk_ins = ~last_cyc | instr_reti | instr_cfg_wr;
        grant   = poll_stb & cand.vld & ~blk_lvl & ~blk_ins;
    end

    intc_srv_track u_srv (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_stb  (grant),
        .set_hi   (cand.hi),
        .reti_stb (reti_stb),
        .in_srv   (in_srv)
    );

    // Registered call outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            call_go  <= 1'b0;
            call_vec <= '0;
            call_src <= '0;
            flag_clr <= '0;
        end else begin
            call_go  <= grant;
            flag_clr <= '0;
            if (grant) begin
                call_src <= cand.idx;
                call_vec <= VEC_W'(VEC_BASE + VEC_STEP * int'(cand.idx));
                flag_clr <= CLR_ON_CALL & (N_SRC'(1) << cand.idx);
            end
        end
    end

    a_r11_only_after_poll: assert property (@(posedge clk) disable iff (!rst_n)
        call_go |-> $past(poll_stb));
    a_r6_needs_last_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        call_go |-> $past(last_cyc));
    a_r7_not_in_reti_or_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        call_go |-> !($past(instr_reti) || $past(instr_cfg_wr)));
    a_r5_high_blocks_all: assert property (@(posedge clk) disable iff (!rst_n)
        call_go |-> !$past(in_srv[1]));
    a_r3_master_enable: assert property (@(posedge clk) disable iff (!rst_n)
        call_go |-> $past(en_q[N_SRC]));
    a_r9_clear_with_call: assert property (@(posedge clk) disable iff (!rst_n)
        (|flag_clr) |-> call_go);
    a_r9_clear_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flag_clr));
endmodule

// File: tb/tb_intc_two_level.sv
module tb_intc_two_level;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_stb = 1'b0, poll_stb = 1'b0, last_cyc = 1'b1;
    logic       instr_reti = 1'b0, instr_cfg_wr = 1'b0, reti_stb = 1'b0;
    logic [4:0] req_raw = '0;
    logic       en_we = 1'b0, pri_we = 1'b0;
    logic [5:0] en_wd = '0;
    logic [4:0] pri_wd = '0;
    logic        call_go;
    logic [15:0] call_vec;
    logic [2:0]  call_src;
    logic [4:0]  flag_clr;
    logic [1:0]  in_srv;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    intc_two_level dut (
        .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .poll_stb(poll_stb),
        .last_cyc(last_cyc), .instr_reti(instr_reti), .instr_cfg_wr(instr_cfg_wr),
        .reti_stb(reti_stb), .req_raw(req_raw), .en_we(en_we), .en_wd(en_wd),
        .pri_we(pri_we), .pri_wd(pri_wd), .call_go(call_go), .call_vec(call_vec),
        .call_src(call_src), .flag_clr(flag_clr), .in_srv(in_srv)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic write_cfg(input logic [5:0] en, input logic [4:0] pri, input bit wp);
        en_we = 1'b1; en_wd = en; pri_we = wp; pri_wd = pri;
        @(negedge clk);
        en_we = 1'b0; pri_we = 1'b0;
    endtask

    task automatic sample(input logic [4:0] req);
        req_raw = req; sample_stb = 1'b1;
        @(negedge clk);
        sample_stb = 1'b0;
    endtask

    task automatic poll(input logic lc, input logic ir, input logic icw);
        last_cyc = lc; instr_reti = ir; instr_cfg_wr = icw; poll_stb = 1'b1;
        @(negedge clk);
        poll_stb = 1'b0; last_cyc = 1'b1; instr_reti = 1'b0; instr_cfg_wr = 1'b0;
    endtask

    task automatic reti();
        reti_stb = 1'b1;
        @(negedge clk);
        reti_stb = 1'b0;
    endtask

    // Checks a grant of source idx at level hi (R8, R9, R11).
    task automatic expect_call(input int idx, input logic [1:0] srv);
        check("R11 call_go", 32'(call_go), 32'd1);
        check("R8 call_src", 32'(call_src), 32'(idx));
        check("R8 call_vec", 32'(call_vec), 32'(3 + 8 * idx));
        check("R9 flag_clr", 32'(flag_clr), (idx == 1 || idx == 3) ? 32'(1 << idx) : 32'd0);
        check("R11 in_srv", 32'(in_srv), 32'(srv));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state right after reset.
        check("R1 call_go", 32'(call_go), 32'd0);
        check("R1 in_srv", 32'(in_srv), 32'd0);
        check("R1 flag_clr", 32'(flag_clr), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: enables are off after reset.
        sample(5'b11111);
        poll(1, 0, 0);
        check("R1 enables cleared", 32'(call_go), 32'd0);
        // R1: priorities are low after reset, so index 0 beats index 4.
        write_cfg(6'b111111, 5'b0, 1'b0);
        sample(5'b10001);
        poll(1, 0, 0);
        check("R1 priorities cleared", 32'(call_src), 32'd0);
        check("R1 call_go", 32'(call_go), 32'd1);
        reti();

        // R4/R8/R9/R11: sweep every pending set against every priority set.
        for (int p = 0; p < 32; p++) begin
            write_cfg(6'b111111, 5'(p), 1'b1);
            for (int r = 0; r < 32; r++) begin
                logic [4:0] hs, us;
                int idx;
                hs = 5'(r & p);
                us = (hs != 0) ? hs : 5'(r);
                idx = 0;
                for (int i = 4; i >= 0; i--) if (us[i]) idx = i;
                sample(5'(r));
                poll(1, 0, 0);
                if (r == 0) begin
                    check("R4 no request", 32'(call_go), 32'd0);
                end else begin
                    check("R4 winner", 32'(call_src), 32'(idx));
                    expect_call(idx, (hs != 0) ? 2'b10 : 2'b01);
                    reti();
                    check("R10 cleared", 32'(in_srv), 32'd0);
                end
            end
        end

        // R3: sweep the enable register with all sources requesting.
        for (int e = 0; e < 64; e++) begin
            logic vld;
            int idx;
            write_cfg(6'(e), 5'b0, 1'b1);
            vld = (e[5] == 1'b1) && (e[4:0] != 0);
            idx = 0;
            for (int i = 4; i >= 0; i--) if (e[i]) idx = i;
            sample(5'b11111);
            poll(1, 0, 0);
            check("R3 enable gate", 32'(call_go), 32'(vld));
            if (vld) begin
                check("R3 enabled winner", 32'(call_src), 32'(idx));
                reti();
            end
        end

        write_cfg(6'b111111, 5'b0, 1'b1);
        // R2: a flag dropped after capture is still polled.
        sample(5'b00100);
        req_raw = 5'b0;
        poll(1, 0, 0);
        check("R2 held capture", 32'(call_go), 32'd1);
        check("R2 held source", 32'(call_src), 32'd2);
        reti();
        // R2: a flag raised after capture is not polled.
        sample(5'b0);
        req_raw = 5'b00001;
        poll(1, 0, 0);
        check("R2 late flag", 32'(call_go), 32'd0);

        // R6: not the last cycle of the instruction.
        sample(5'b00010);
        poll(0, 0, 0);
        check("R6 blocked", 32'(call_go), 32'd0);
        poll(1, 0, 0);
        check("R6 released", 32'(call_go), 32'd1);
        reti();

        // R7: return or configuration write in progress.
        sample(5'b01000);
        poll(1, 1, 0);
        check("R7 reti blocks", 32'(call_go), 32'd0);
        poll(1, 0, 1);
        check("R7 cfg write blocks", 32'(call_go), 32'd0);
        poll(1, 0, 0);
        expect_call(3, 2'b01);
        reti();

        // R5/R10: nesting with the serial source on the high level.
        write_cfg(6'b111111, 5'b10000, 1'b1);
        sample(5'b00001);
        poll(1, 0, 0);
        expect_call(0, 2'b01);
        sample(5'b00010);
        poll(1, 0, 0);
        check("R5 same low level", 32'(call_go), 32'd0);
        sample(5'b10000);
        poll(1, 0, 0);
        check("R5 high preempts", 32'(call_go), 32'd1);
        expect_call(4, 2'b11);
        poll(1, 0, 0);
        check("R5 equal high level", 32'(call_go), 32'd0);
        reti();
        check("R10 low exposed", 32'(in_srv), 32'd1);
        sample(5'b00010);
        poll(1, 0, 0);
        check("R5 low still running", 32'(call_go), 32'd0);
        reti();
        check("R10 all clear", 32'(in_srv), 32'd0);
        poll(1, 0, 0);
        expect_call(1, 2'b01);
        reti();

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule